// File: doc/BRIEF.md
# Memory Channel Interleave Decoder

This block maps a physical memory address to the memory channel that holds it. A memory controller or an error-logging path presents an address along with the interleave configuration. That configuration is the channel way count, the socket-way shift, a one-bit extra shift and a hash-enable flag. One clock later the block returns a two-bit channel number, an error flag and a valid strobe.

For two- and four-way interleave the index is a two-bit slice of the address. The slice starts at bit 6 and moves up by the socket-way shift and the extra shift. When hashing is on, pairs of address bits from 12 to 27 are XOR-folded into that slice. Three-way interleave ignores the slice and the hash. It reduces the address above bit 6 modulo 3, using a digit-sum circuit in place of a divider. One-way interleave always returns channel 0.

Top module: `chan_interleave_dec`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock. A synchronous active-high `rst` forces `out_valid`, `out_chan` and `out_err` to 0 on the next clock.
- R2: When `way_cnt` is 3, `out_chan` is `phys_addr[45:6]` taken modulo 3.
- R3: When `way_cnt` is 3, `hash_en`, `sock_shift` and `shift_up` have no effect on `out_chan`.
- R4: When `way_cnt` is 2 or 4 and `hash_en` is 0, the index is the two address bits starting at position 6 + `sock_shift` + `shift_up` (lower bit first). `out_chan` is that index modulo `way_cnt`.
- R5: When `hash_en` is 1 and `way_cnt` is 2 or 4, bit 0 of the index is XORed with address bits 12, 14, …, 26. Bit 1 is XORed with bits 13, 15, …, 27. The modulo step comes after this XOR.
- R6: With hashing on, address bits above 27 have no effect on `out_chan`, and neither do bits 12 to 27 taken in XOR-cancelling pairs.
- R7: A `way_cnt` outside 1 to 4 (the values 0, 5, 6 and 7) sets `out_err` to 1 and `out_chan` to 0. A `way_cnt` from 1 to 4 sets `out_err` to 0.
- R8: When `way_cnt` is 1, `out_chan` is 0 for every address and option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| phys_addr | input | 46 | Physical address |
| way_cnt | input | 3 | Channel way count (1, 2, 3 or 4) |
| sock_shift | input | 2 | Socket-way shift, 0 to 3 |
| shift_up | input | 1 | Extra index shift of one bit |
| hash_en | input | 1 | Enables XOR folding of address bits 12 to 27 |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_chan | output | 2 | Decoded channel |
| out_err | output | 1 | Way count not supported |

## Verification
Assertions check the following on every clock: the one-cycle valid latency, the error flag against the previous way count, a zero channel whenever the error flag is set, a channel below the way count, and a zero channel in one-way mode. Only the bench's sweeps can show that the channel value is correct. Those sweeps cover the modulo-3 result over many addresses, the bit position chosen by each shift combination, the exact XOR fold, and the independence of the result from address bits the mode ignores.

// File: rtl/chan_dec_pkg.sv
package chan_dec_pkg;

    localparam int ADDR_W    = 46;
    localparam int BASE_BIT  = 6;
    localparam int WAY_W     = 3;
    localparam int CHAN_W    = 2;
    localparam int SOCK_W    = 2;
    localparam int HASH_LO   = 12;
    localparam int HASH_HI   = 27;
    localparam int UPPER_W   = ADDR_W - BASE_BIT;
    localparam int POS_W     = $clog2(ADDR_W);

    typedef enum logic [WAY_W-1:0] {
        WAYS_ONE   = 3'd1,
        WAYS_TWO   = 3'd2,
        WAYS_THREE = 3'd3,
        WAYS_FOUR  = 3'd4
    } way_mode_e;

    typedef struct packed {
        logic              err;
        logic [CHAN_W-1:0] chan;
    } dec_result_t;

    // Sum of the 2-bit digits of a 16-bit value (4 == 1 mod 3, so mod 3 is kept)
    function automatic logic [15:0] digit_fold(input logic [15:0] v);
        logic [15:0] s;
        s = '0;
        for (int k = 0; k < 8; k++) begin
            s = s + 16'(v[2*k +: 2]);
        end
        return s;
    endfunction

    function automatic logic way_supported(input logic [WAY_W-1:0] w);
        return (w >= 3'd1) && (w <= 3'd4);
    endfunction

endpackage

// File: rtl/chan_mod3.sv
module chan_mod3
    import chan_dec_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] value,
    output logic [1:0]   rem
);
    localparam int NDIG = (W + 1) / 2;
    localparam int PADW = 2 * NDIG;

    logic [PADW-1:0] padded;
    logic [15:0]     stage [0:4];

    assign padded = PADW'(value);

    always_comb begin
        stage[0] = '0;
        for (int d = 0; d < NDIG; d++) begin
            stage[0] = stage[0] + 16'(padded[2*d +: 2]);
        end
    end

    generate
        for (genvar g = 1; g <= 4; g++) begin : g_fold
            assign stage[g] = digit_fold(stage[g-1]);
        end
    endgenerate

    assign rem = (stage[4][1:0] == 2'd3) ? 2'd0 : stage[4][1:0];

endmodule

// File: rtl/chan_hash_fold.sv
module chan_hash_fold
    import chan_dec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LO = HASH_LO,
    parameter int HI = HASH_HI
) (
    input  logic [AW-1:0] addr,
    output logic [1:0]    fold
);
    localparam int NPAIR = (HI - LO + 1) / 2;

    logic [1:0] acc [0:NPAIR];

    assign acc[0] = 2'b00;

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            assign acc[p+1] = acc[p] ^ addr[LO + 2*p +: 2];
        end
    endgenerate

    assign fold = acc[NPAIR];

endmodule

// File: rtl/chan_interleave_dec.sv
module chan_interleave_dec
    import chan_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] phys_addr,
    input  logic [WAY_W-1:0]  way_cnt,
    input  logic [SOCK_W-1:0] sock_shift,
    input  logic              shift_up,
    input  logic              hash_en,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan,
    output logic              out_err
);
    logic [POS_W-1:0]  slice_pos;
    logic [1:0]        raw_idx;
    logic [1:0]        fold_bits;
    logic [1:0]        mixed_idx;
    logic [1:0]        rem3;
    dec_result_t       comb_res;
    dec_result_t       res_q;
    logic              valid_q;

    chan_hash_fold #(.AW(ADDR_W), .LO(HASH_LO), .HI(HASH_HI)) i_fold (
        .addr (phys_addr),
        .fold (fold_bits)
    );

    chan_mod3 #(.W(UPPER_W)) i_mod3 (
        .value (phys_addr[ADDR_W-1:BASE_BIT]),
        .rem   (rem3)
    );

    assign slice_pos = POS_W'(BASE_BIT) + POS_W'(sock_shift) + POS_W'(shift_up);
    assign raw_idx   = phys_addr[slice_pos +: 2];
    assign mixed_idx = hash_en ? (raw_idx ^ fold_bits) : raw_idx;

    always_comb begin
        comb_res = '0;
        case (way_mode_e'(way_cnt))
            WAYS_ONE:   comb_res.chan = 2'd0;
            WAYS_TWO:   comb_res.chan = {1'b0, mixed_idx[0]};
            WAYS_THREE: comb_res.chan = rem3;
            WAYS_FOUR:  comb_res.chan = mixed_idx;
            default:    comb_res.err  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            res_q   <= comb_res;
        end
    end

    assign out_valid = valid_q;
    assign out_chan  = res_q.chan;
    assign out_err   = res_q.err;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R1

    AST_ERR_MATCHES_WAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid) |-> (out_err == !way_supported($past(way_cnt)))); // R7

    AST_ERR_CHAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_chan == 2'd0)); // R7

    AST_CHAN_BELOW_WAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && !out_err) |-> (3'(out_chan) < $past(way_cnt))); // R2

    AST_ONE_WAY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && $past(way_cnt) == 3'd1) |-> (out_chan == 2'd0)); // R8

endmodule

// File: tb/test_chan_interleave_dec.sv
module test_chan_interleave_dec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [45:0] phys_addr = '0;
    logic [2:0]  way_cnt = 3'd1;
    logic [1:0]  sock_shift = '0;
    logic        shift_up = 1'b0;
    logic        hash_en = 1'b0;
    logic        out_valid;
    logic [1:0]  out_chan;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    always #5 clk = ~clk;

    chan_interleave_dec i_chan_interleave_dec (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phys_addr(phys_addr),
        .way_cnt(way_cnt), .sock_shift(sock_shift), .shift_up(shift_up),
        .hash_en(hash_en), .out_valid(out_valid), .out_chan(out_chan), .out_err(out_err)
    );

    function automatic logic [2:0] model(input logic [45:0] a, input int w,
                                         input int s, input int u, input bit h);
        longint unsigned idx;
        if (w < 1 || w > 4) return 3'b100;  // {err, chan}
        if (w == 3) return {1'b0, 2'(((64'(a)) >> 6) % 3)};
        idx = (64'(a) >> (6 + s + u)) & 3;
        if (h) for (int i = 12; i < 28; i += 2) idx ^= (64'(a) >> i) & 3;
        return {1'b0, 2'(idx % longint'(w))};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [45:0] next_addr();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
        return lfsr[45:0];
    endfunction

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic run(input logic [45:0] a, input int w, input int s, input int u,
                       input bit h, output logic [2:0] got);
        @(negedge clk);
        in_valid = 1'b1; phys_addr = a; way_cnt = 3'(w);
        sock_shift = 2'(s); shift_up = 1'(u); hash_en = h;
        @(negedge clk);
        got = {out_err, out_chan};
        check("R1 valid", 32'(out_valid), 32'd1);
    endtask

    initial begin : watchdog
        #1500000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [2:0] got, got2;
        logic [45:0] a;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 0);
        check("R1 reset chan", 32'(out_chan), 0);
        check("R1 reset err", 32'(out_err), 0);
        rst = 1'b0;

        for (int n = 0; n < 14; n++) begin
            if (n == 0) a = '0;
            else if (n == 1) a = '1;
            else if (n == 2) a = 46'h0000_0FFF_FFC0;
            else a = next_addr();
            for (int w = 0; w < 8; w++)
                for (int s = 0; s < 4; s++)
                    for (int u = 0; u < 2; u++)
                        for (int h = 0; h < 2; h++) begin
                            run(a, w, s, u, h[0], got);
                            if (w < 1 || w > 4) check("R7 invalid way", 32'(got), 32'(model(a, w, s, u, h[0])));
                            else if (w == 3) check("R2 R3 three-way", 32'(got), 32'(model(a, w, s, u, h[0])));
                            else if (w == 1) check("R8 one-way", 32'(got), 32'(model(a, w, s, u, h[0])));
                            else if (h != 0) check("R5 hashed", 32'(got), 32'(model(a, w, s, u, h[0])));
                            else check("R4 slice", 32'(got), 32'(model(a, w, s, u, h[0])));
                        end
        end

        // R6: upper bits and cancelling pairs inside the hash window do not matter
        for (int n = 0; n < 40; n++) begin
            a = next_addr();
            run(a, 4, n % 4, n % 2, 1'b1, got);
            run(a ^ 46'h3FFF_F000_0000 ^ 46'h0000_0000_5000, 4, n % 4, n % 2, 1'b1, got2);
            check("R6 hash-invariant bits", 32'(got2), 32'(got));
        end

        // R3: three-way result identical across all options for one address
        a = 46'h2345_6789_ABCD;
        run(a, 3, 0, 0, 1'b0, got);
        run(a, 3, 3, 1, 1'b1, got2);
        check("R3 options ignored", 32'(got2), 32'(got));

        // R1: valid drops one cycle after in_valid drops
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 valid low", 32'(out_valid), 0);

        // R1: mid-run reset clears outputs
        in_valid = 1'b1; way_cnt = 3'd6;
        @(negedge clk);
        check("R7 err set", 32'(out_err), 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 0);
        check("R1 reset err", 32'(out_err), 0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule